// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block sits in the pixel path of a frame buffer with two picture planes and one control plane. Each incoming pixel brings three values: an index into a colour table, a direct-colour word and a control word. The two 32-bit words arrive exactly as memory holds them, in big-endian byte order. The block reorders the bytes of each word. From the control word it decides whether the pixel shows its own 24-bit colour or the table entry that the index selects. It emits one 32-bit pixel, with RGB in the low 24 bits, plus a flag that tells which path produced it.

The colour table is outside the block. The selector drives a read strobe and an address in the cycle it accepts a pixel, and takes the entry on `pal_data` one cycle later. Every pixel, direct or indexed, goes through one register stage, so pixels leave in the order they arrived.

Both streams use valid/ready. A pixel is accepted on a rising edge where `in_valid` and `in_ready` are both high. It is delivered on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the stage is empty or its pixel leaves in the same cycle. While `out_valid` is high and `out_ready` is low, the presented pixel and flag stay frozen, and the table may drive anything on `pal_data`.

Top module: `pix_colour_select`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A pixel is direct only when raw control bits [7:0] equal 0x03; these are the bits that land in [31:24] once the word's bytes are reversed. `out_mode` is 1 for a direct pixel and 0 for an indexed one.
- R3: For a direct pixel, `out_pixel[23:0]` equals {in_direct[15:8], in_direct[23:16], in_direct[31:24]}. This is the low 24 bits of the byte-reversed word, so red is taken from raw bits [15:8].
- R4: In the accepting cycle, `pal_rd` is 1 and `pal_addr` equals `in_index`. For an indexed pixel, `out_pixel[23:0]` is the value on `pal_data` in the following cycle.
- R5: `out_pixel[31:24]` is always 0.
- R6: A pixel accepted on one edge is presented with `out_valid` high right after that edge. The block holds at most one pixel.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_pixel` and `out_mode` keep their values, whatever the table drives on `pal_data`.
- R8: `in_ready` equals (!out_valid || out_ready). Every accepted pixel is delivered exactly once, in order.
- R9: Control bits [31:8] and direct-word bits [7:0] have no effect on the output. For example, raw 0x03000000 is an indexed pixel, and raw 0xFFFFFF03 is a direct pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_index | input | IDX_W | Colour table index |
| in_direct | input | 32 | Direct-colour word, big-endian |
| in_ctrl | input | 32 | Control-plane word, big-endian |
| pal_rd | output | 1 | Colour table read strobe |
| pal_addr | output | IDX_W | Colour table address |
| pal_data | input | 24 | Table entry, valid the cycle after `pal_rd` |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the pixel |
| out_pixel | output | 32 | Pixel, RGB in [23:0], [31:24] zero |
| out_mode | output | 1 | 1 = direct colour, 0 = table colour |

## Verification
Random pixels mix control low bytes of exactly 0x03 with bytes that differ from it by one. This separates a correct exact-match test from a partial-bit or wrong-byte decode. Directed words place the code byte in the top raw byte and fill the other control bytes with ones, which exposes a decode done without the byte reversal. Direct words carry a distinct value in every byte, so a wrong byte order or an included low byte shows up as a colour mismatch. The bench table returns random garbage in every cycle without a read. Random stalls of the sink then show whether a table colour is captured rather than re-read, and whether pixels are lost or repeated.

// File: rtl/pix_sel_pkg.sv
package pix_sel_pkg;
  localparam int WORD_W = 32;
  localparam int RGB_W  = 24;

  // reverse byte order of a memory word
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++)
      r[8*b +: 8] = w[WORD_W-8-8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pix_decode.sv
module pix_decode
  import pix_sel_pkg::*;
#(
  parameter logic [7:0] DIRECT_CODE = 8'h03
) (
  input  logic [WORD_W-1:0] ctrl_be,
  input  logic [WORD_W-1:0] direct_be,
  output logic              is_direct,
  output logic [RGB_W-1:0]  direct_rgb
);
  logic [WORD_W-1:0] ctrl_sw;
  logic [WORD_W-1:0] dir_sw;
  logic              unused_bits;

  always_comb begin
    ctrl_sw    = swap_bytes(ctrl_be);
    dir_sw     = swap_bytes(direct_be);
    is_direct  = (ctrl_sw[WORD_W-1 -: 8] == DIRECT_CODE);
    direct_rgb = dir_sw[RGB_W-1:0];
  end

  assign unused_bits = ^{ctrl_sw[WORD_W-9:0], dir_sw[WORD_W-1:RGB_W]};
endmodule

// File: rtl/pix_hold_stage.sv
module pix_hold_stage
  import pix_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_direct,
  input  logic [RGB_W-1:0] take_rgb,
  input  logic [RGB_W-1:0] pal_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_mode,
  output logic [RGB_W-1:0] out_rgb
);
  logic             s_valid;
  logic             s_mode;
  logic             s_fresh;   // table entry is on pal_data this cycle
  logic [RGB_W-1:0] s_rgb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_mode  <= 1'b0;
      s_fresh <= 1'b0;
      s_rgb   <= '0;
    end else if (take) begin
      s_valid <= 1'b1;
      s_mode  <= take_direct;
      s_fresh <= !take_direct;
      s_rgb   <= take_rgb;
    end else begin
      if (out_ready) s_valid <= 1'b0;
      if (s_fresh) begin
        s_rgb   <= pal_data;   // capture once; the table may change later
        s_fresh <= 1'b0;
      end
    end
  end

  assign out_valid = s_valid;
  assign out_mode  = s_mode;
  assign out_rgb   = s_fresh ? pal_data : s_rgb;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_mode)));
  // R6
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !take) |=> !out_valid);
endmodule

// File: rtl/pix_colour_select.sv
module pix_colour_select
  import pix_sel_pkg::*;
#(
  parameter int         IDX_W       = 8,
  parameter logic [7:0] DIRECT_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [WORD_W-1:0] in_direct,
  input  logic [WORD_W-1:0] in_ctrl,
  output logic              pal_rd,
  output logic [IDX_W-1:0]  pal_addr,
  input  logic [RGB_W-1:0]  pal_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pixel,
  output logic              out_mode
);
  localparam int PAD_W = WORD_W - RGB_W;

  logic             take;
  logic             dec_direct;
  logic [RGB_W-1:0] dec_rgb;
  logic [RGB_W-1:0] st_rgb;

  pix_decode #(.DIRECT_CODE(DIRECT_CODE)) u_dec (
    .ctrl_be    (in_ctrl),
    .direct_be  (in_direct),
    .is_direct  (dec_direct),
    .direct_rgb (dec_rgb)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign pal_rd   = take;
  assign pal_addr = in_index;

  pix_hold_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .take_direct (dec_direct),
    .take_rgb    (dec_rgb),
    .pal_data    (pal_data),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_mode    (out_mode),
    .out_rgb     (st_rgb)
  );

  assign out_pixel = {{PAD_W{1'b0}}, st_rgb};

  // R6
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R2
  mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_mode == ($past(in_ctrl[7:0]) == DIRECT_CODE)));
  // R3
  direct_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ctrl[7:0] == DIRECT_CODE) |=>
      (out_pixel[23:0] == {$past(in_direct[15:8]), $past(in_direct[23:16]), $past(in_direct[31:24])}));
  // R4
  table_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ctrl[7:0] != DIRECT_CODE) |=> (out_pixel[23:0] == pal_data));
endmodule

// File: tb/pix_colour_select_test.sv
`timescale 1ns/1ps
module pix_colour_select_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_direct = '0;
  logic [31:0] in_ctrl = '0;
  logic        pal_rd;
  logic [7:0]  pal_addr;
  logic [23:0] pal_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixel;
  logic        out_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pix_colour_select uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
    .pal_rd(pal_rd), .pal_addr(pal_addr), .pal_data(pal_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_mode(out_mode)
  );

  function automatic logic [23:0] tbl(input logic [7:0] i);
    return {i ^ 8'h5a, ~i, i + 8'h31};
  endfunction

  // table model: entry one cycle after a read, garbage otherwise
  always @(posedge clk) pal_data <= pal_rd ? tbl(pal_addr) : 24'($urandom);

  function automatic logic [32:0] expect_px(input logic [7:0] idx, input logic [31:0] d,
                                            input logic [31:0] c);
    if (c[7:0] == 8'h03) return {1'b1, 8'h00, d[15:8], d[23:16], d[31:24]};
    return {1'b0, 8'h00, tbl(idx)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [32:0] q[$];
  bit          prev_stall = 0;
  logic [32:0] prev_out;
  bit          prev_take = 0;

  // one cycle: drive at negedge, observe, let the edge happen
  task automatic cycle(input bit v, input logic [7:0] idx, input logic [31:0] d,
                       input logic [31:0] c, input bit rdy);
    @(negedge clk);
    if (prev_take) check("R6 valid after accept", 64'(out_valid), 64'd1);
    if (prev_stall) check("R7 held under stall", 64'({out_mode, out_pixel}), 64'(prev_out));
    if (out_valid) check("R5 top byte", 64'(out_pixel[31:24]), 64'd0);
    in_valid = v; in_index = idx; in_direct = d; in_ctrl = c; out_ready = rdy;
    #1;
    check("R8 ready rule", 64'(in_ready), 64'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (q.size() == 0) check("R8 extra pixel", 64'd1, 64'd0);
      else begin
        logic [32:0] e = q.pop_front();
        check(e[32] ? "R3 direct colour / R2 R9 mode" : "R4 table colour / R2 R9 mode",
              64'({out_mode, out_pixel}), 64'(e));
      end
    end
    prev_take  = v && in_ready;
    if (prev_take) begin
      check("R4 table read", 64'({pal_rd, pal_addr}), 64'({1'b1, idx}));
      q.push_back(expect_px(idx, d, c));
    end
    prev_stall = out_valid && !out_ready;
    prev_out   = {out_mode, out_pixel};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset ready", 64'(in_ready), 64'd1);
    // directed corners
    cycle(1, 8'h11, 32'hA1B2C3D4, 32'h00000003, 1);   // R2 direct
    cycle(1, 8'h22, 32'hA1B2C3D4, 32'h03000000, 1);   // R9 code in wrong byte
    cycle(1, 8'h33, 32'h102030FF, 32'hFFFFFF03, 1);   // R9 other bytes ignored
    cycle(1, 8'h44, 32'h0, 32'h00000002, 0);          // R2 near miss, stall R7
    cycle(0, 8'h00, 32'h0, 32'h0, 0);
    cycle(0, 8'h00, 32'h0, 32'h0, 1);
    cycle(1, 8'hFF, 32'h0, 32'h00000007, 1);          // R2 near miss
    cycle(1, 8'h00, 32'hDEADBEEF, 32'h00000003, 0);   // direct under stall R7
    cycle(0, 8'h00, 32'h0, 32'h0, 0);
    cycle(0, 8'h00, 32'h0, 32'h0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] c = $urandom;
      case ($urandom % 4)
        0, 1: c[7:0] = 8'h03;
        2: c[7:0] = 8'h03 ^ (8'h1 << ($urandom % 8));
        default: ;
      endcase
      cycle(($urandom % 4) != 0, 8'($urandom), $urandom, c, ($urandom % 3) != 0);
    end
    for (int i = 0; i < 4; i++) cycle(0, 8'h00, 32'h0, 32'h0, 1);
    check("R8 all delivered", 64'(q.size()), 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule